// File: doc/BRIEF.md
# System Peripheral Window Decoder with Security Banking

This block sits in front of the processor's private peripheral space, a 1 MiB window based at 0xE0000000. Each request carries an address, a read/write flag, a secure attribute and a user (unprivileged) attribute. The decoder picks at most one internal target per request and drives a one-hot strobe to it. The targets are the system-control register file, two copies of a tick timer (one per security state) and an optional reliability (RAS) register block. Overlapping address ranges are settled by a fixed priority: the timer wins over system control, and both win over the catch-all default space.

When the v8 feature is on, a second 4 KiB window re-presents the system-control and timer space. Secure code uses it to reach the non-secure bank: the request goes to the same target as the main address, with the secure attribute cleared. A non-secure request to that window, like any request that no target claims, reads zero and drops writes when privileged, and faults when unprivileged. Decoding is combinational. Read data from the chosen target, or zero, is registered with an error flag and returned one cycle later.

Parameters turn off the alias window, the secure timer bank and the RAS block. A range whose feature is off falls through to the default behaviour.

Top module: `ppb_window_decoder`

## Requirements
- R1: `tgt_sel` is one-hot or zero, and it is zero in any cycle where `req_valid` is low. Bit 0 selects system control, bit 1 the non-secure timer bank, bit 2 the secure timer bank and bit 3 the RAS block.
- R2: Addresses 0xE000E000–0xE000EFFF outside the timer window select system control (bit 0).
- R3: Addresses 0xE000E010–0xE000E0EF select a timer bank. The bank is bit 2 when the effective secure attribute is 1 and bit 1 otherwise. With `SEC_BANK_EN`=0 every timer access selects bit 1.
- R4: With `RAS_EN`=1, addresses 0xE0005000–0xE0005FFF select the RAS block (bit 3). With `RAS_EN`=0 they are default space.
- R5: A privileged request inside the window that no target claims raises `hit_default`, selects no target, and is answered one cycle later with `rsp_rdata`=0 and `rsp_err`=0.
- R6: A user request that no target claims is answered with `rsp_err`=1.
- R7: With `V8_EN`=1, a secure request to 0xE002E000–0xE002EFFF raises `hit_alias` and selects the same target as the address 0x20000 lower, with `tgt_secure`=0.
- R8: A non-secure request to the alias window raises `hit_alias` and selects no target. It is answered with zero data and no error when privileged, and with `rsp_err`=1 when user.
- R9: With `V8_EN`=0 the alias range is ordinary default space (`hit_default`=1, `hit_alias`=0).
- R10: A request outside 0xE0000000–0xE00FFFFF selects nothing and is answered with `rsp_err`=1 whatever its privilege.
- R11: `rsp_valid` equals `req_valid` one cycle earlier. `rsp_rdata` holds the selected target's read data for a read that selected a target, and zero otherwise. Reset clears all response outputs.
- R12: `tgt_offset` equals `req_addr[11:0]`, and `tgt_write`/`tgt_wdata` pass the request's flag and data through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the request |
| req_user | input | 1 | Unprivileged attribute of the request |
| req_wdata | input | DATA_W | Write data |
| tgt_rdata | input | NUM_TGT*DATA_W | Read data of each target, slot t at bits t*DATA_W |
| tgt_sel | output | NUM_TGT | One-hot target strobe |
| tgt_offset | output | OFFS_W | Offset within the 4 KiB target page |
| tgt_write | output | 1 | Write flag forwarded to the target |
| tgt_wdata | output | DATA_W | Write data forwarded to the target |
| tgt_secure | output | 1 | Secure attribute after alias rewriting |
| hit_default | output | 1 | Request fell into unclaimed window space |
| hit_alias | output | 1 | Request hit the non-secure alias window |
| rsp_valid | output | 1 | Registered response present |
| rsp_rdata | output | DATA_W | Registered read data |
| rsp_err | output | 1 | Registered bus error |

## Verification
The bound checker checks on every cycle the properties that hold for any single request. The select is one-hot and idle when no request is present. The secure timer bank never receives a non-secure request. A non-secure alias hit never reaches a target, and a forwarded alias hit always loses its secure attribute. The default space answers zero without error for privileged reads and with an error for user requests, out-of-window requests always fault, and the response follows the request by one cycle. Only the bench scenarios show that each address lands on the correct target. These cover the exact window edges (0xE000E00F/0xE000E010, 0xE000E0EF/0xE000E0F0, the RAS page limits, the window end) and the routing with each feature parameter off, on a second instance. They also show that the returned data comes from that target's slot.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  // Target slots in tgt_sel / tgt_rdata
  localparam int TGT_SYSCTL = 0;
  localparam int TGT_TMR_NS = 1;
  localparam int TGT_TMR_S  = 2;
  localparam int TGT_RAS    = 3;
  localparam int NUM_TGT    = 4;

  // Address ranges matched in parallel
  localparam int RGN_WINDOW = 0;
  localparam int RGN_SC     = 1;
  localparam int RGN_TMR    = 2;
  localparam int RGN_ASC    = 3;
  localparam int RGN_ATMR   = 4;
  localparam int RGN_RAS    = 5;
  localparam int NUM_RGN    = 6;

  localparam logic [31:0] WIN_BASE   = 32'hE000_0000;
  localparam logic [31:0] WIN_SIZE   = 32'h0010_0000;
  localparam logic [31:0] SC_BASE    = 32'hE000_E000;
  localparam logic [31:0] ALIAS_BASE = 32'hE002_E000;
  localparam logic [31:0] RAS_BASE   = 32'hE000_5000;
  localparam logic [31:0] PAGE_SIZE  = 32'h0000_1000;
  localparam logic [31:0] TMR_OFFS   = 32'h0000_0010;
  localparam logic [31:0] TMR_SIZE   = 32'h0000_00E0;

  function automatic logic [31:0] rgn_base(int idx);
    case (idx)
      RGN_WINDOW: return WIN_BASE;
      RGN_SC:     return SC_BASE;
      RGN_TMR:    return SC_BASE + TMR_OFFS;
      RGN_ASC:    return ALIAS_BASE;
      RGN_ATMR:   return ALIAS_BASE + TMR_OFFS;
      default:    return RAS_BASE;
    endcase
  endfunction

  function automatic logic [31:0] rgn_size(int idx);
    case (idx)
      RGN_WINDOW:         return WIN_SIZE;
      RGN_TMR, RGN_ATMR:  return TMR_SIZE;
      default:            return PAGE_SIZE;
    endcase
  endfunction

  function automatic bit rgn_enabled(int idx, bit v8_en, bit ras_en);
    case (idx)
      RGN_ASC, RGN_ATMR: return v8_en;
      RGN_RAS:           return ras_en;
      default:           return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/ppb_rgn_match.sv
module ppb_rgn_match #(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '0,
  parameter bit              EN     = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] rel;

  assign rel = addr - BASE;

  generate
    if (EN) begin : g_on
      assign hit = (addr >= BASE) && (rel < SIZE);
    end else begin : g_off
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ppb_route.sv
module ppb_route
  import ppb_pkg::*;
#(
  parameter bit SEC_BANK_EN = 1'b1
) (
  input  logic               valid,
  input  logic [NUM_RGN-1:0] hits,
  input  logic               secure,
  input  logic               user,
  output logic [NUM_TGT-1:0] sel,
  output logic               eff_secure,
  output logic               dflt,
  output logic               alias_hit,
  output logic               err
);
  logic in_win;
  logic in_alias;
  logic in_tmr;
  logic in_sc;

  assign in_win   = hits[RGN_WINDOW];
  assign in_alias = hits[RGN_ASC];
  assign in_tmr   = hits[RGN_TMR] | hits[RGN_ATMR];
  assign in_sc    = hits[RGN_SC]  | hits[RGN_ASC];

  always_comb begin
    sel        = '0;
    eff_secure = secure;
    dflt       = 1'b0;
    alias_hit  = 1'b0;
    err        = 1'b0;
    if (valid) begin
      if (!in_win) begin
        err = 1'b1;
      end else if (in_alias && !secure) begin
        alias_hit = 1'b1;
        err       = user;
      end else begin
        alias_hit  = in_alias;
        eff_secure = in_alias ? 1'b0 : secure;
        if (in_tmr) begin
          if (SEC_BANK_EN && eff_secure) sel[TGT_TMR_S]  = 1'b1;
          else                           sel[TGT_TMR_NS] = 1'b1;
        end else if (in_sc) begin
          sel[TGT_SYSCTL] = 1'b1;
        end else if (hits[RGN_RAS]) begin
          sel[TGT_RAS] = 1'b1;
        end else begin
          dflt = 1'b1;
          err  = user;
        end
      end
    end
  end
endmodule

// File: rtl/ppb_resp.sv
module ppb_resp #(
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid,
  input  logic                      write,
  input  logic                      err_now,
  input  logic [NUM_TGT-1:0]        sel,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (sel[t]) rd_mux = rd_mux | tgt_rdata[t*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid;
      rsp_rdata <= (valid && !write) ? rd_mux : '0;
      rsp_err   <= valid && err_now;
    end
  end
endmodule

// File: rtl/ppb_window_decoder.sv
module ppb_window_decoder
  import ppb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFFS_W      = 12,
  parameter bit V8_EN       = 1'b1,
  parameter bit SEC_BANK_EN = 1'b1,
  parameter bit RAS_EN      = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic                      req_secure,
  input  logic                      req_user,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  output logic [NUM_TGT-1:0]        tgt_sel,
  output logic [OFFS_W-1:0]         tgt_offset,
  output logic                      tgt_write,
  output logic [DATA_W-1:0]         tgt_wdata,
  output logic                      tgt_secure,
  output logic                      hit_default,
  output logic                      hit_alias,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err
);
  logic [NUM_RGN-1:0] hits;
  logic               err_now;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    ppb_rgn_match #(
      .ADDR_W (ADDR_W),
      .BASE   (ADDR_W'(rgn_base(g))),
      .SIZE   (ADDR_W'(rgn_size(g))),
      .EN     (rgn_enabled(g, V8_EN, RAS_EN))
    ) i_match (
      .addr (req_addr),
      .hit  (hits[g])
    );
  end

  ppb_route #(
    .SEC_BANK_EN (SEC_BANK_EN)
  ) i_route (
    .valid      (req_valid),
    .hits       (hits),
    .secure     (req_secure),
    .user       (req_user),
    .sel        (tgt_sel),
    .eff_secure (tgt_secure),
    .dflt       (hit_default),
    .alias_hit  (hit_alias),
    .err        (err_now)
  );

  ppb_resp #(
    .DATA_W  (DATA_W),
    .NUM_TGT (NUM_TGT)
  ) i_resp (
    .clk       (clk),
    .rst       (rst),
    .valid     (req_valid),
    .write     (req_write),
    .err_now   (err_now),
    .sel       (tgt_sel),
    .tgt_rdata (tgt_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  assign tgt_offset = req_addr[OFFS_W-1:0];
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
endmodule

// File: rtl/ppb_checker.sv
module ppb_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_write,
  input logic               req_secure,
  input logic               req_user,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic               tgt_secure,
  input logic               hit_default,
  input logic               hit_alias,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_err
);
  logic outside;
  assign outside = req_addr[ADDR_W-1:20] != 12'hE00;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));
  a_r1_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> tgt_sel == '0);
  a_r3_secure_bank_secure_only: assert property (@(posedge clk) disable iff (rst)
    tgt_sel[2] |-> tgt_secure);
  a_r5_default_no_target: assert property (@(posedge clk) disable iff (rst)
    hit_default |-> tgt_sel == '0);
  a_r5_default_raz: assert property (@(posedge clk) disable iff (rst)
    hit_default && !req_user && !req_write |=> rsp_rdata == '0 && !rsp_err);
  a_r6_default_user_fault: assert property (@(posedge clk) disable iff (rst)
    hit_default && req_user |=> rsp_err);
  a_r7_alias_clears_secure: assert property (@(posedge clk) disable iff (rst)
    hit_alias && tgt_sel != '0 |-> !tgt_secure);
  a_r8_alias_ns_blocked: assert property (@(posedge clk) disable iff (rst)
    hit_alias && !req_secure |-> tgt_sel == '0);
  a_r10_outside_fault: assert property (@(posedge clk) disable iff (rst)
    req_valid && outside |=> rsp_err);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_err);
endmodule

bind ppb_window_decoder ppb_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_TGT (ppb_pkg::NUM_TGT)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_write   (req_write),
  .req_secure  (req_secure),
  .req_user    (req_user),
  .tgt_sel     (tgt_sel),
  .tgt_secure  (tgt_secure),
  .hit_default (hit_default),
  .hit_alias   (hit_alias),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err)
);

// File: tb/test_ppb_window_decoder.sv
module test_ppb_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NT = 4;

  typedef struct packed {
    logic [3:0] sel;
    logic       dflt;
    logic       alias_h;
    logic       fsec;
    logic       err;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_write = 1'b0, req_secure = 1'b0, req_user = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [NT*DW-1:0] tgt_rdata = '0;

  logic [NT-1:0] f_sel, m_sel;
  logic [11:0] f_off, m_off;
  logic f_wr, m_wr, f_sec, m_sec, f_dflt, m_dflt, f_al, m_al;
  logic [DW-1:0] f_wd, m_wd, f_rd, m_rd;
  logic f_rv, m_rv, f_re, m_re;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppb_window_decoder i_ppb_window_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_secure(req_secure), .req_user(req_user),
    .req_wdata(req_wdata), .tgt_rdata(tgt_rdata), .tgt_sel(f_sel),
    .tgt_offset(f_off), .tgt_write(f_wr), .tgt_wdata(f_wd), .tgt_secure(f_sec),
    .hit_default(f_dflt), .hit_alias(f_al), .rsp_valid(f_rv),
    .rsp_rdata(f_rd), .rsp_err(f_re));

  ppb_window_decoder #(.V8_EN(1'b0), .SEC_BANK_EN(1'b0), .RAS_EN(1'b0)) i_ppb_window_decoder_min (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_secure(req_secure), .req_user(req_user),
    .req_wdata(req_wdata), .tgt_rdata(tgt_rdata), .tgt_sel(m_sel),
    .tgt_offset(m_off), .tgt_write(m_wr), .tgt_wdata(m_wd), .tgt_secure(m_sec),
    .hit_default(m_dflt), .hit_alias(m_al), .rsp_valid(m_rv),
    .rsp_rdata(m_rd), .rsp_err(m_re));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_rng(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return a >= lo && a <= hi;
  endfunction

  // Expected routing, written from the requirement list
  function automatic exp_t model(logic [31:0] a, bit sec, bit usr, bit v8, bit bank2, bit ras);
    exp_t e = '0;
    bit al, eff, sc, tm;
    al = v8 && in_rng(a, 32'hE002_E000, 32'hE002_EFFF);
    e.fsec = sec;
    if (!in_rng(a, 32'hE000_0000, 32'hE00F_FFFF)) begin
      e.err = 1'b1;                                  // R10
    end else if (al && !sec) begin
      e.alias_h = 1'b1; e.err = usr;                 // R8
    end else begin
      eff = al ? 1'b0 : sec;                         // R7
      e.alias_h = al; e.fsec = eff;
      sc = al || in_rng(a, 32'hE000_E000, 32'hE000_EFFF);
      tm = sc && (a[11:0] >= 12'h010) && (a[11:0] <= 12'h0EF);
      if (tm)      e.sel = (bank2 && eff) ? 4'b0100 : 4'b0010;   // R3
      else if (sc) e.sel = 4'b0001;                              // R2
      else if (ras && in_rng(a, 32'hE000_5000, 32'hE000_5FFF)) e.sel = 4'b1000; // R4
      else begin e.dflt = 1'b1; e.err = usr; end                 // R5 R6
    end
    return e;
  endfunction

  function automatic string tag_of(logic [31:0] a, bit sec, bit usr, bit v8, exp_t e);
    if (e.err && !e.dflt && !e.alias_h) return "R10";
    if (!v8 && in_rng(a, 32'hE002_E000, 32'hE002_EFFF)) return "R9";
    if (e.alias_h) return sec ? "R7" : "R8";
    if (e.sel[1] || e.sel[2]) return "R3";
    if (e.sel[0]) return "R2";
    if (e.sel[3]) return "R4";
    return usr ? "R6" : "R5";
  endfunction

  function automatic logic [DW-1:0] exp_rd(exp_t e, bit wr, logic [NT*DW-1:0] rd);
    logic [DW-1:0] v = '0;
    if (!wr) for (int t = 0; t < NT; t++) if (e.sel[t]) v = rd[t*DW +: DW];
    return v;
  endfunction

  task automatic check_dut(input string nm, input bit v8, input bit b2, input bit ras,
                           input logic [3:0] sel, input logic dflt, input logic al,
                           input logic sec, input logic [11:0] off, input logic wr,
                           input logic [DW-1:0] wd);
    exp_t e = model(req_addr, req_secure, req_user, v8, b2, ras);
    string tg = tag_of(req_addr, req_secure, req_user, v8, e);
    check($onehot0(sel), "R1", {nm, " sel onehot"}, 64'(sel), 64'(e.sel));
    check(sel == e.sel, tg, {nm, " sel"}, 64'(sel), 64'(e.sel));
    check(dflt == e.dflt, tg, {nm, " hit_default"}, 64'(dflt), 64'(e.dflt));
    check(al == e.alias_h, tg, {nm, " hit_alias"}, 64'(al), 64'(e.alias_h));
    if (e.sel != 0) check(sec == e.fsec, tg, {nm, " tgt_secure"}, 64'(sec), 64'(e.fsec));
    check(off == req_addr[11:0] && wr == req_write && wd == req_wdata, "R12",
          {nm, " passthrough"}, 64'(off), 64'(req_addr[11:0]));
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input bit sec, input bit usr);
    exp_t ef, em;
    logic [NT*DW-1:0] rd;
    @(negedge clk);
    for (int t = 0; t < NT; t++) tgt_rdata[t*DW +: DW] = $urandom;
    req_valid = 1'b1; req_addr = a; req_write = wr; req_secure = sec;
    req_user = usr; req_wdata = $urandom;
    #1;
    check_dut("full", 1'b1, 1'b1, 1'b1, f_sel, f_dflt, f_al, f_sec, f_off, f_wr, f_wd);
    check_dut("min", 1'b0, 1'b0, 1'b0, m_sel, m_dflt, m_al, m_sec, m_off, m_wr, m_wd);
    ef = model(a, sec, usr, 1'b1, 1'b1, 1'b1);
    em = model(a, sec, usr, 1'b0, 1'b0, 1'b0);
    rd = tgt_rdata;
    @(posedge clk); #1;
    check(f_rv == 1'b1, "R11", "full rsp_valid", 64'(f_rv), 64'd1);
    check(f_rd == exp_rd(ef, wr, rd), "R11", "full rsp_rdata", 64'(f_rd), 64'(exp_rd(ef, wr, rd)));
    check(f_re == ef.err, tag_of(a, sec, usr, 1'b1, ef), "full rsp_err", 64'(f_re), 64'(ef.err));
    check(m_rd == exp_rd(em, wr, rd), "R11", "min rsp_rdata", 64'(m_rd), 64'(exp_rd(em, wr, rd)));
    check(m_re == em.err, tag_of(a, sec, usr, 1'b0, em), "min rsp_err", 64'(m_re), 64'(em.err));
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] off = 32'($urandom_range(0, 4095));
    case ($urandom_range(0, 7))
      0: return 32'hE000_E000 + off;
      1: return 32'hE000_E000 + 32'($urandom_range(0, 255));
      2: return 32'hE002_E000 + off;
      3: return 32'hE002_E000 + 32'($urandom_range(0, 255));
      4: return 32'hE000_5000 + off;
      5: return 32'hE000_0000 + 32'($urandom_range(0, 32'h000F_FFFF));
      6: return 32'hE010_0000 + off;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R11: reset state
    check(f_rv == 0 && f_rd == 0 && f_re == 0, "R11", "reset response", 64'(f_rv), 64'd0);
    // R1: idle cycle selects nothing and gives no response
    #1; check(f_sel == 0 && m_sel == 0, "R1", "idle sel", 64'(f_sel), 64'd0);
    @(posedge clk); #1;
    check(f_rv == 0 && f_re == 0, "R11", "idle response", 64'(f_rv), 64'd0);

    // Directed edges: R2 R3 R4 R5 R6 R7 R8 R9 R10
    access(32'hE000_E00F, 1'b0, 1'b0, 1'b0);
    access(32'hE000_E010, 1'b0, 1'b1, 1'b0);
    access(32'hE000_E010, 1'b0, 1'b0, 1'b1);
    access(32'hE000_E0EF, 1'b0, 1'b1, 1'b1);
    access(32'hE000_E0F0, 1'b0, 1'b1, 1'b0);
    access(32'hE000_EFFF, 1'b1, 1'b0, 1'b0);
    access(32'hE000_F000, 1'b0, 1'b0, 1'b0);
    access(32'hE000_F000, 1'b0, 1'b0, 1'b1);
    access(32'hE000_5000, 1'b0, 1'b1, 1'b0);
    access(32'hE000_5FFF, 1'b0, 1'b0, 1'b1);
    access(32'hE000_4FFC, 1'b0, 1'b0, 1'b0);
    access(32'hE00F_FFFF, 1'b0, 1'b0, 1'b0);
    access(32'hE010_0000, 1'b0, 1'b0, 1'b0);
    access(32'hDFFF_FFFC, 1'b1, 1'b1, 1'b0);
    access(32'hE002_E010, 1'b0, 1'b1, 1'b0);
    access(32'hE002_E100, 1'b0, 1'b1, 1'b1);
    access(32'hE002_E010, 1'b0, 1'b0, 1'b0);
    access(32'hE002_E010, 1'b0, 1'b0, 1'b1);
    access(32'hE002_EFFF, 1'b1, 1'b0, 1'b0);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      access(pick_addr(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); req_valid = 1'b0; #1;
        check(f_sel == 0 && m_sel == 0, "R1", "gap sel", 64'(f_sel), 64'd0);
        @(posedge clk); #1;
        check(f_rv == 0 && m_rv == 0, "R11", "gap response", 64'(f_rv), 64'd0);
      end
    end

    @(negedge clk); req_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule